// File: doc/BRIEF.md
# Supply and Clock Health Supervisor

This block watches the health of a clock synthesis board. A temperature reading and a set of supply-rail readings arrive with a strobe. Each reading is compared against its own programmable low and high limits. Three status lines from the phase-locked loop are watched continuously: loop locked, reference present and oscillator running. A failure on any of these sets a cause bit in an 8-bit alarm word. A cause bit stays set until the host reads the word. The read returns the word and clears it.

The block drives an alarm output, which is high while any cause bit is set. It also drives a two-colour status lamp: red while an alarm is latched and green otherwise. Each time the host bus addresses the unit, the lamp goes dark for a programmable number of clocks. This blink shows the host that the unit was addressed.

The lamp is controlled by a small state machine with two states. In `FL_STEADY` the lamp shows the fault colour. In `FL_DARK` both colour drives are off while a counter runs down. The transitions are:
- **hit**: `FL_STEADY` to `FL_DARK` on an access strobe.
- **retrigger**: `FL_DARK` to `FL_DARK` on an access strobe, which reloads the counter.
- **expire**: `FL_DARK` to `FL_STEADY` when the counter reaches zero with no access strobe present.

Top module: `health_monitor`

## Requirements
- R1: The alarm word has this layout: bit 0 loop unlocked, bit 1 reference missing, bit 2 oscillator stopped, bit 3 temperature out of window, bit 4 any supply rail out of window. Bits 7 to 5 always read 0.
- R2: If `pll_locked`, `ref_present` or `vco_running` is low on a clock edge, the matching bit (0, 1 or 2) is set in `alarm_word` one cycle later.
- R3: When `sample_valid` is high, bit 3 sets one cycle later if `temp_rd` is strictly below `temp_min` or strictly above `temp_max`. All three values are signed 16-bit numbers in units of 0.01 °C. A reading equal to either limit does not set the bit.
- R4: Rail k uses bits [16k+15:16k] of `volt_rd`, `volt_min` and `volt_max`. The values are unsigned millivolts. Rail 0 is the CPU supply, rail 1 the PLL supply, rail 2 the charge pump and rail 3 the pre-regulator. When `sample_valid` is high, bit 4 sets one cycle later if any rail is strictly below its minimum or strictly above its maximum. A rail equal to either limit does not set the bit.
- R5: When `sample_valid` is low, the temperature and rail readings have no effect on `alarm_word`.
- R6: A set cause bit stays set after its condition clears, for as long as `alarm_rd` is not asserted.
- R7: In the cycle that `alarm_rd` is high, `alarm_word` shows the latched causes. On the next cycle every bit is clear, except bits whose condition was present during the read cycle.
- R8: `alarm_out` is high exactly when any bit of `alarm_word` is set.
- R9: Outside a blink, `led_red` equals `alarm_out` and `led_green` is its inverse. The two are never high together.
- R10: A `bus_hit` pulse turns both lamp drives off for exactly FLASH_CYCLES cycles, starting the cycle after the pulse.
- R11: A `bus_hit` pulse during a blink restarts the FLASH_CYCLES dark period from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Readings and limits are valid this cycle |
| temp_rd | input | 16 | Temperature reading, signed, 0.01 °C |
| temp_min | input | 16 | Lower temperature limit, signed |
| temp_max | input | 16 | Upper temperature limit, signed |
| volt_rd | input | 64 | Four rail readings, mV, rail k at [16k+15:16k] |
| volt_min | input | 64 | Four rail lower limits |
| volt_max | input | 64 | Four rail upper limits |
| pll_locked | input | 1 | Loop lock status, high when locked |
| ref_present | input | 1 | Reference detected, high when present |
| vco_running | input | 1 | Oscillator detected, high when running |
| alarm_rd | input | 1 | Host read strobe for the alarm word |
| bus_hit | input | 1 | Host access addressed to this unit |
| alarm_word | output | 8 | Latched alarm causes |
| alarm_out | output | 1 | High while any cause is latched |
| led_red | output | 1 | Red lamp drive |
| led_green | output | 1 | Green lamp drive |

## Verification
The properties assume that `alarm_rd` and `bus_hit` are single-cycle pulses. They also assume that the status lines stay stable between the clock edges the bench chooses. The sticky-bit property assumes nothing clears a bit except a read strobe in the previous cycle. The bench drives every input on the falling edge and holds the status lines high, unless a scenario drops them on purpose. Each read or access strobe lasts one cycle. Limits are held constant while a sample is strobed, so each window decision depends only on the reading that scenario chose.

// File: rtl/hm_pkg.sv
package hm_pkg;
    localparam int ALARM_W   = 8;
    localparam int CAUSE_W   = 5;
    localparam int B_UNLOCK  = 0;
    localparam int B_NOREF   = 1;
    localparam int B_NOVCO   = 2;
    localparam int B_TEMP    = 3;
    localparam int B_RAIL    = 4;

    typedef enum logic [0:0] {
        FL_STEADY = 1'b0,
        FL_DARK   = 1'b1
    } flash_state_t;
endpackage

// File: rtl/hm_window_cmp.sv
module hm_window_cmp #(
    parameter int DW        = 16,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [DW-1:0] reading,
    input  logic [DW-1:0] lim_lo,
    input  logic [DW-1:0] lim_hi,
    output logic          outside
);
    generate
        if (IS_SIGNED) begin : g_signed
            always_comb
                outside = ($signed(reading) < $signed(lim_lo)) ||
                          ($signed(reading) > $signed(lim_hi));
        end else begin : g_unsigned
            always_comb
                outside = (reading < lim_lo) || (reading > lim_hi);
        end
    endgenerate
endmodule

// File: rtl/hm_cause_latch.sv
module hm_cause_latch
    import hm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAUSE_W-1:0]  set_vec,
    input  logic                clr,
    output logic [ALARM_W-1:0]  word
);
    logic [CAUSE_W-1:0] held;

    genvar i;
    generate
        for (i = 0; i < CAUSE_W; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    held[i] <= 1'b0;
                else
                    held[i] <= (held[i] & ~clr) | set_vec[i];
            end
        end
    endgenerate

    always_comb word = {{(ALARM_W-CAUSE_W){1'b0}}, held};
endmodule

// File: rtl/hm_flash_fsm.sv
module hm_flash_fsm
    import hm_pkg::*;
#(
    parameter int FLASH_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic fault,
    output logic red,
    output logic green
);
    localparam int CNT_W = (FLASH_CYCLES > 1) ? $clog2(FLASH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(FLASH_CYCLES - 1);

    flash_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FL_STEADY: begin
                if (hit) begin
                    state_nx = FL_DARK;
                    cnt_nx   = RELOAD;
                end
            end
            FL_DARK: begin
                if (hit) begin
                    cnt_nx = RELOAD;
                end else if (cnt == '0) begin
                    state_nx = FL_STEADY;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: begin
                state_nx = FL_STEADY;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FL_STEADY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        red   = 1'b0;
        green = 1'b0;
        unique case (state)
            FL_STEADY: begin
                red   = fault;
                green = ~fault;
            end
            FL_DARK: begin
                red   = 1'b0;
                green = 1'b0;
            end
            default: begin
                red   = 1'b0;
                green = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/health_monitor.sv
module health_monitor
    import hm_pkg::*;
#(
    parameter int DW           = 16,
    parameter int NUM_RAILS    = 4,
    parameter int FLASH_CYCLES = 1000000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic [DW-1:0]           temp_rd,
    input  logic [DW-1:0]           temp_min,
    input  logic [DW-1:0]           temp_max,
    input  logic [NUM_RAILS*DW-1:0] volt_rd,
    input  logic [NUM_RAILS*DW-1:0] volt_min,
    input  logic [NUM_RAILS*DW-1:0] volt_max,
    input  logic                    pll_locked,
    input  logic                    ref_present,
    input  logic                    vco_running,
    input  logic                    alarm_rd,
    input  logic                    bus_hit,
    output logic [ALARM_W-1:0]      alarm_word,
    output logic                    alarm_out,
    output logic                    led_red,
    output logic                    led_green
);
    logic                 temp_out;
    logic [NUM_RAILS-1:0] rail_out;
    logic [CAUSE_W-1:0]   causes;

    hm_window_cmp #(.DW(DW), .IS_SIGNED(1'b1)) u_temp (
        .reading (temp_rd),
        .lim_lo  (temp_min),
        .lim_hi  (temp_max),
        .outside (temp_out)
    );

    genvar k;
    generate
        for (k = 0; k < NUM_RAILS; k++) begin : g_rail
            hm_window_cmp #(.DW(DW), .IS_SIGNED(1'b0)) u_rail (
                .reading (volt_rd [k*DW +: DW]),
                .lim_lo  (volt_min[k*DW +: DW]),
                .lim_hi  (volt_max[k*DW +: DW]),
                .outside (rail_out[k])
            );
        end
    endgenerate

    always_comb begin
        causes            = '0;
        causes[B_UNLOCK]  = ~pll_locked;
        causes[B_NOREF]   = ~ref_present;
        causes[B_NOVCO]   = ~vco_running;
        causes[B_TEMP]    = sample_valid & temp_out;
        causes[B_RAIL]    = sample_valid & (|rail_out);
    end

    hm_cause_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (causes),
        .clr     (alarm_rd),
        .word    (alarm_word)
    );

    always_comb alarm_out = |alarm_word;

    hm_flash_fsm #(.FLASH_CYCLES(FLASH_CYCLES)) u_lamp (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (bus_hit),
        .fault (alarm_out),
        .red   (led_red),
        .green (led_green)
    );
endmodule

// File: rtl/hm_checker.sv
module hm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_locked,
    input logic       ref_present,
    input logic       vco_running,
    input logic       alarm_rd,
    input logic       bus_hit,
    input logic [7:0] alarm_word,
    input logic       alarm_out,
    input logic       led_red,
    input logic       led_green
);
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_word[7:5] == 3'b000);

    assert_unlock_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> alarm_word[0]);

    assert_noref_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_present |=> alarm_word[1]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_rd |=> ((alarm_word & $past(alarm_word)) == $past(alarm_word)));

    assert_alarm_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_out == (alarm_word != 8'h00));

    assert_lamp_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(led_red && led_green));

    assert_dark_after_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |=> (!led_red && !led_green));
endmodule

bind health_monitor hm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_locked  (pll_locked),
    .ref_present (ref_present),
    .vco_running (vco_running),
    .alarm_rd    (alarm_rd),
    .bus_hit     (bus_hit),
    .alarm_word  (alarm_word),
    .alarm_out   (alarm_out),
    .led_red     (led_red),
    .led_green   (led_green)
);

// File: tb/sim_health_monitor.sv
`timescale 1ns/1ps
module sim_health_monitor;
    localparam int FC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] temp_rd = 16'd2500;
    logic [15:0] temp_min = 16'hFC18;
    logic [15:0] temp_max = 16'd8500;
    logic [63:0] volt_rd = {4{16'd4000}};
    logic [63:0] volt_min = {4{16'd3000}};
    logic [63:0] volt_max = {4{16'd5500}};
    logic        pll_locked = 1'b1;
    logic        ref_present = 1'b1;
    logic        vco_running = 1'b1;
    logic        alarm_rd = 1'b0;
    logic        bus_hit = 1'b0;
    logic [7:0]  alarm_word;
    logic        alarm_out;
    logic        led_red;
    logic        led_green;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    health_monitor #(.FLASH_CYCLES(FC)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .temp_rd(temp_rd), .temp_min(temp_min), .temp_max(temp_max),
        .volt_rd(volt_rd), .volt_min(volt_min), .volt_max(volt_max),
        .pll_locked(pll_locked), .ref_present(ref_present), .vco_running(vco_running),
        .alarm_rd(alarm_rd), .bus_hit(bus_hit), .alarm_word(alarm_word),
        .alarm_out(alarm_out), .led_red(led_red), .led_green(led_green)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_read();
        alarm_rd = 1'b1;
        step();
        alarm_rd = 1'b0;
        step();
    endtask

    task automatic strobe_sample();
        sample_valid = 1'b1;
        step();
        sample_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset word", alarm_word, 8'h00);
        chk("R8 reset alarm_out", alarm_out, 1'b0);
        chk("R9 reset green", {led_red, led_green}, 2'b01);
    endtask

    task automatic t_status();
        pll_locked = 1'b0;
        step();
        chk("R2 unlock bit0", alarm_word, 8'h01);
        chk("R8 alarm_out high", alarm_out, 1'b1);
        chk("R9 red on fault", {led_red, led_green}, 2'b10);
        pll_locked = 1'b1;
        step(); step();
        chk("R6 sticky after recovery", alarm_word, 8'h01);
        alarm_rd = 1'b1;
        #1;
        chk("R7 read shows causes", alarm_word, 8'h01);
        step();
        alarm_rd = 1'b0;
        chk("R7 cleared after read", alarm_word, 8'h00);
        chk("R9 green after clear", {led_red, led_green}, 2'b01);
        ref_present = 1'b0;
        vco_running = 1'b0;
        step();
        ref_present = 1'b1;
        vco_running = 1'b1;
        chk("R2 ref and vco bits", alarm_word, 8'h06);
        do_read();
        chk("R1 cleared", alarm_word, 8'h00);
    endtask

    task automatic t_read_while_present();
        pll_locked = 1'b0;
        step();
        alarm_rd = 1'b1;
        step();
        alarm_rd = 1'b0;
        chk("R7 condition present sets again", alarm_word, 8'h01);
        pll_locked = 1'b1;
        step();
        do_read();
        chk("R7 clear once gone", alarm_word, 8'h00);
    endtask

    task automatic t_temp();
        temp_rd = 16'hFC17;
        strobe_sample();
        chk("R3 below min", alarm_word, 8'h08);
        do_read();
        temp_rd = 16'hFC18;
        strobe_sample();
        chk("R3 equal min no alarm", alarm_word, 8'h00);
        temp_rd = 16'd8500;
        strobe_sample();
        chk("R3 equal max no alarm", alarm_word, 8'h00);
        temp_rd = 16'd8501;
        strobe_sample();
        chk("R3 above max", alarm_word, 8'h08);
        do_read();
        temp_rd = 16'd9000;
        step(); step();
        chk("R5 ignored without strobe", alarm_word, 8'h00);
        temp_rd = 16'd2500;
    endtask

    task automatic t_rails();
        volt_rd[2*16 +: 16] = 16'd5501;
        strobe_sample();
        chk("R4 rail2 above max", alarm_word, 8'h10);
        volt_rd[2*16 +: 16] = 16'd4000;
        do_read();
        volt_rd[3*16 +: 16] = 16'd2999;
        strobe_sample();
        chk("R4 rail3 below min", alarm_word, 8'h10);
        do_read();
        volt_rd[0 +: 16] = 16'd3000;
        volt_rd[3*16 +: 16] = 16'd5500;
        strobe_sample();
        chk("R4 equal limits no alarm", alarm_word, 8'h00);
        volt_rd[1*16 +: 16] = 16'd100;
        step(); step();
        chk("R5 rail ignored without strobe", alarm_word, 8'h00);
        volt_rd = {4{16'd4000}};
    endtask

    task automatic t_flash();
        bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        for (int i = 0; i < FC; i++) begin
            chk("R10 dark during blink", {led_red, led_green}, 2'b00);
            step();
        end
        chk("R10 lamp back after blink", {led_red, led_green}, 2'b01);
    endtask

    task automatic t_retrigger();
        bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        step();
        bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        for (int i = 0; i < FC; i++) begin
            chk("R11 dark after retrigger", {led_red, led_green}, 2'b00);
            step();
        end
        chk("R11 lamp back", {led_red, led_green}, 2'b01);
        pll_locked = 1'b0;
        step();
        pll_locked = 1'b1;
        bus_hit = 1'b1;
        step();
        bus_hit = 1'b0;
        chk("R10 dark over fault", {led_red, led_green}, 2'b00);
        repeat (FC) step();
        chk("R9 red after blink", {led_red, led_green}, 2'b10);
        do_read();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_status();
        t_read_while_present();
        t_temp();
        t_rails();
        t_flash();
        t_retrigger();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule